// File: doc/BRIEF.md
# Scan Test Sequencer with Chain Integrity Check

This controller drives a full-scan design through a complete manufacturing test of its combinational logic. A single `start` pulse launches a fixed sequence. First the scan chain is flushed with a repeating 0,0,1,1 pattern to confirm that every cell shifts and holds both values. Then a list of stored test vectors is applied. For each vector the present-state bits are shifted into the chain, and one clock in normal mode captures the next state while the primary inputs carry the vector's values. A final shift unloads the last response.

While a vector is loaded, the response of the previous vector leaves the chain, and the sequencer compares each scan-out bit with the stored expected response. The primary outputs are compared during the capture clock. Any mismatch sets a sticky fail flag. A clock counter runs across the whole sequence. A done flag rises when the counter reaches the closed-form length (NVEC+2)·NSFF + NVEC + 4, where NSFF is the chain length and NVEC is the number of vectors.

The vectors, primary-input values, expected outputs and expected responses are parameters of the module. Loading them at run time is not supported.

Top module: `scan_test_seq`

## Requirements
- R1: While reset is low, and after reset until the first `start`, `busy`, `done`, `fail`, `scan_en`, `scan_in`, `pi` and `cycle_cnt` are all zero.
- R2: A `start` pulse while idle begins the flush in the next clock. For NSFF+4 clocks `scan_en` is 1 and `scan_in` follows 0,0,1,1 repeating, starting with the first flush clock.
- R3: In the last four flush clocks, `scan_out` is compared with the bit shifted in NSFF clocks earlier. A mismatch sets `fail`.
- R4: Each vector is loaded in NSFF clocks with `scan_en` at 1. `scan_in` gives state bit NSFF-1 first and bit 0 last, so that the cell next to `scan_out` holds bit NSFF-1.
- R5: Each load is followed by exactly one capture clock with `scan_en` at 0 and `pi` equal to that vector's primary-input value. On every other clock, and while idle, `pi` is zero.
- R6: During each capture clock, `po` is compared with the vector's expected output. A mismatch sets `fail`.
- R7: On each shift of the second and later loads, and on each clock of the final NSFF-clock unload, `scan_out` is compared with the previous vector's expected response, bit NSFF-1 first. During the final unload `scan_in` is 0.
- R8: `cycle_cnt` is 0 in the first clock of the sequence and increases by one per clock. When it reaches (NVEC+2)·NSFF+NVEC+4, `busy` falls, `done` rises, and both stay that way until the next `start`.
- R9: `fail` is sticky until the next accepted `start`, which clears both `fail` and `done`.
- R10: A `start` pulse while `busy` is 1 is ignored: the count and the sequence continue unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch the test sequence when idle |
| scan_out | input | 1 | Serial output of the scan chain under test |
| po | input | NPO | Primary outputs of the design under test |
| scan_en | output | 1 | 1 = shift mode, 0 = normal (capture) mode |
| scan_in | output | 1 | Serial input to the scan chain |
| pi | output | NPI | Primary inputs applied to the design under test |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence completed |
| fail | output | 1 | Sticky mismatch flag |
| cycle_cnt | output | CNT_W | Clocks elapsed in the current or last sequence |

## Verification
The sequencer runs against a small scan-wrapped model with four cells, an adder as next-state logic, and one vector whose sum wraps. The model is run fault-free and with three injected defects: a chain cell stuck at 0, an inverted primary output, and a next-state error. Each defect is caught by a different comparison window (flush, capture or unload), so each run shows which window does its job. On every clock the bench also checks the shift and capture control pattern. A run with a `start` pulse in mid-sequence shows that such a pulse is ignored. A clean run after a failing one shows that `start` clears the sticky flag.

// File: rtl/scan_test_seq.sv
module scan_test_seq #(
  parameter int NSFF  = 4,
  parameter int NPI   = 2,
  parameter int NPO   = 2,
  parameter int NVEC  = 3,
  parameter int CNT_W = 16,
  parameter logic [NVEC*NSFF-1:0] VEC_STATE = {4'hF, 4'hA, 4'h3},
  parameter logic [NVEC*NPI-1:0]  VEC_PI    = {2'b01, 2'b10, 2'b01},
  parameter logic [NVEC*NPO-1:0]  EXP_PO    = {2'b10, 2'b00, 2'b01},
  parameter logic [NVEC*NSFF-1:0] EXP_RESP  = {4'h0, 4'hC, 4'h4}
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             scan_out,
  input  logic [NPO-1:0]   po,
  output logic             scan_en,
  output logic             scan_in,
  output logic [NPI-1:0]   pi,
  output logic             busy,
  output logic             done,
  output logic             fail,
  output logic [CNT_W-1:0] cycle_cnt
);
  localparam int TOTAL = (NVEC + 2) * NSFF + NVEC + 4;
  localparam int BW = $clog2(NSFF + 5);
  localparam int VW = (NVEC > 1) ? $clog2(NVEC) : 1;
  localparam int SW = (NSFF > 1) ? $clog2(NSFF) : 1;

  typedef enum logic [1:0] {PH_FLUSH, PH_LOAD, PH_CAPT, PH_UNLOAD} phase_t;

  phase_t          ph;
  logic [BW-1:0]   bit_i;
  logic [VW-1:0]   vec_i;
  logic [VW-1:0]   rsp_i;
  logic [BW-1:0]   ridx;
  logic [BW-1:0]   fl_off;
  logic [NSFF-1:0] cur_state;
  logic [NSFF-1:0] cur_resp;
  logic [NPI-1:0]  cur_pi;
  logic [NPO-1:0]  cur_po;
  logic            chk_shift;
  logic            exp_bit;
  logic            mismatch;

  assign ridx   = BW'(NSFF - 1) - bit_i;
  assign fl_off = bit_i - BW'(NSFF);
  assign rsp_i  = (ph == PH_UNLOAD) ? VW'(NVEC - 1) :
                  (vec_i == '0) ? '0 : vec_i - 1'b1;

  assign cur_state = VEC_STATE[int'(vec_i) * NSFF +: NSFF];
  assign cur_resp  = EXP_RESP[int'(rsp_i) * NSFF +: NSFF];
  assign cur_pi    = VEC_PI[int'(vec_i) * NPI +: NPI];
  assign cur_po    = EXP_PO[int'(vec_i) * NPO +: NPO];

  assign scan_en = busy && (ph != PH_CAPT);
  assign pi      = (busy && ph == PH_CAPT) ? cur_pi : '0;

  always_comb begin
    scan_in = 1'b0;
    if (busy) begin
      case (ph)
        PH_FLUSH: scan_in = bit_i[1];
        PH_LOAD:  scan_in = cur_state[ridx[SW-1:0]];
        default:  scan_in = 1'b0;
      endcase
    end
  end

  assign chk_shift = busy && ((ph == PH_FLUSH && bit_i >= BW'(NSFF)) ||
                              (ph == PH_LOAD && vec_i != '0) ||
                              (ph == PH_UNLOAD));
  assign exp_bit   = (ph == PH_FLUSH) ? fl_off[1] : cur_resp[ridx[SW-1:0]];
  assign mismatch  = (chk_shift && (scan_out != exp_bit)) ||
                     (busy && ph == PH_CAPT && po != cur_po);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      fail      <= 1'b0;
      cycle_cnt <= '0;
      ph        <= PH_FLUSH;
      bit_i     <= '0;
      vec_i     <= '0;
    end else if (start && !busy) begin
      busy      <= 1'b1;
      done      <= 1'b0;
      fail      <= 1'b0;
      cycle_cnt <= '0;
      ph        <= PH_FLUSH;
      bit_i     <= '0;
      vec_i     <= '0;
    end else if (busy) begin
      cycle_cnt <= cycle_cnt + 1'b1;
      if (mismatch) fail <= 1'b1;
      case (ph)
        PH_FLUSH: begin
          if (bit_i == BW'(NSFF + 3)) begin
            ph    <= PH_LOAD;
            bit_i <= '0;
          end else begin
            bit_i <= bit_i + 1'b1;
          end
        end
        PH_LOAD: begin
          if (bit_i == BW'(NSFF - 1)) begin
            ph    <= PH_CAPT;
            bit_i <= '0;
          end else begin
            bit_i <= bit_i + 1'b1;
          end
        end
        PH_CAPT: begin
          if (vec_i == VW'(NVEC - 1)) begin
            ph <= PH_UNLOAD;
          end else begin
            ph    <= PH_LOAD;
            vec_i <= vec_i + 1'b1;
          end
        end
        default: begin
          if (bit_i == BW'(NSFF - 1)) begin
            busy  <= 1'b0;
            done  <= 1'b1;
            bit_i <= '0;
          end else begin
            bit_i <= bit_i + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

module scan_test_seq_chk #(
  parameter int NPI   = 2,
  parameter int CNT_W = 16,
  parameter int TOTAL = 27
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic             fail,
  input logic             scan_en,
  input logic [NPI-1:0]   pi,
  input logic [CNT_W-1:0] cycle_cnt
);
  p_capt_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !scan_en) |=> (scan_en || !busy));

  p_pi_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy || scan_en) |-> (pi == '0));

  p_count_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (cycle_cnt == $past(cycle_cnt) + CNT_W'(1)));

  p_done_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (cycle_cnt == CNT_W'(TOTAL) && !busy));

  p_fail_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !(start && !busy)) |=> fail);

  p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (cycle_cnt != '0));
endmodule

bind scan_test_seq scan_test_seq_chk #(
  .NPI(NPI), .CNT_W(CNT_W), .TOTAL((NVEC + 2) * NSFF + NVEC + 4)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .fail(fail), .scan_en(scan_en), .pi(pi), .cycle_cnt(cycle_cnt)
);

// File: tb/scan_test_seq_tb.sv
module scan_test_seq_tb_top;
  localparam int NSFF  = 4;
  localparam int NPI   = 2;
  localparam int NPO   = 2;
  localparam int NVEC  = 3;
  localparam int CNT_W = 16;
  localparam int TOTAL = (NVEC + 2) * NSFF + NVEC + 4;

  localparam logic [3:0] VST [3] = '{4'h3, 4'hA, 4'hF};
  localparam logic [1:0] VPI [3] = '{2'b01, 2'b10, 2'b01};

  // run table: {fault mode[2:0] -> bits 2:1, expected fail -> bit 0}
  localparam int NRUN = 5;
  localparam logic [2:0] RUNS [NRUN] = '{3'b000, 3'b011, 3'b101, 3'b111, 3'b000};

  logic clk = 0;
  logic rst_n = 0;
  logic start = 0;
  logic [1:0] fault_mode = 0;
  logic scan_out;
  logic [NPO-1:0] po;
  logic scan_en, scan_in, busy, done, fail;
  logic [NPI-1:0] pi;
  logic [CNT_W-1:0] cycle_cnt;

  int errs = 0;
  int checks = 0;

  always #5 clk = ~clk;

  // scan-wrapped model: 4 cells, next state = state + pi, po = state[3:2] ^ pi
  logic [3:0] sc = 4'h0;
  logic [3:0] sc_eff;
  assign sc_eff   = (fault_mode == 2'd1) ? (sc & 4'b1011) : sc;
  assign scan_out = sc_eff[3];
  assign po       = sc_eff[3:2] ^ pi ^ ((fault_mode == 2'd2) ? 2'b01 : 2'b00);
  always @(posedge clk) begin
    if (scan_en) sc <= {sc_eff[2:0], scan_in};
    else sc <= sc_eff + {2'b00, pi} + ((fault_mode == 2'd3) ? 4'd1 : 4'd0);
  end

  scan_test_seq #(
    .NSFF(NSFF), .NPI(NPI), .NPO(NPO), .NVEC(NVEC), .CNT_W(CNT_W),
    .VEC_STATE({4'hF, 4'hA, 4'h3}), .VEC_PI({2'b01, 2'b10, 2'b01}),
    .EXP_PO({2'b10, 2'b00, 2'b01}), .EXP_RESP({4'h0, 4'hC, 4'h4})
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .scan_out(scan_out), .po(po),
    .scan_en(scan_en), .scan_in(scan_in), .pi(pi), .busy(busy), .done(done),
    .fail(fail), .cycle_cnt(cycle_cnt)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  task automatic run_seq(input logic [1:0] fm, input bit exp_fail, input bit mid_start);
    int e_flush = 0, e_load = 0, e_capt = 0, e_unl = 0, e_cnt = 0;
    fault_mode = fm;
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    chk(fail == 0 && done == 0, "R9 start clears fail/done", int'(fail) + 2 * int'(done), 0);
    for (int c = 0; c < TOTAL; c++) begin
      if (cycle_cnt != CNT_W'(c) || !busy || done) e_cnt++;
      if (c < NSFF + 4) begin
        if (!scan_en || scan_in != ((c >> 1) & 1) || pi != 0) e_flush++;
      end else if (c < NSFF + 4 + NVEC * (NSFF + 1)) begin
        int k = c - (NSFF + 4);
        int v = k / (NSFF + 1);
        int p = k % (NSFF + 1);
        if (p < NSFF) begin
          if (!scan_en || scan_in != VST[v][NSFF - 1 - p] || pi != 0) e_load++;
        end else begin
          if (scan_en || pi != VPI[v]) e_capt++;
        end
      end else begin
        if (!scan_en || scan_in != 0 || pi != 0) e_unl++;
      end
      if (mid_start && c == 10) start = 1;
      @(negedge clk);
      start = 0;
    end
    chk(e_flush == 0, "R2 flush control pattern", e_flush, 0);
    chk(e_load == 0, "R4 load order and scan mode", e_load, 0);
    chk(e_capt == 0, "R5 capture clock and pi", e_capt, 0);
    chk(e_unl == 0, "R7 unload scan_in low", e_unl, 0);
    chk(e_cnt == 0, mid_start ? "R10 mid-run start ignored" : "R8 count per clock", e_cnt, 0);
    chk(done && !busy && cycle_cnt == CNT_W'(TOTAL), "R8 done at closed-form total",
        int'(cycle_cnt), TOTAL);
    case (fm)
      2'd1: chk(fail == exp_fail, "R3 stuck chain cell detected", int'(fail), int'(exp_fail));
      2'd2: chk(fail == exp_fail, "R6 primary output mismatch", int'(fail), int'(exp_fail));
      2'd3: chk(fail == exp_fail, "R7 response mismatch", int'(fail), int'(exp_fail));
      default: chk(fail == exp_fail, "R3/R6/R7 clean run no fail", int'(fail), int'(exp_fail));
    endcase
    repeat (3) @(negedge clk);
    chk(done && !busy && cycle_cnt == CNT_W'(TOTAL) && fail == exp_fail,
        "R8 R9 done and fail held when idle", int'(cycle_cnt), TOTAL);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk({busy, done, fail, scan_en, scan_in} == 5'b0 && pi == 0 && cycle_cnt == 0,
        "R1 outputs in reset", int'({busy, done, fail, scan_en, scan_in}), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk({busy, done, fail, scan_en, scan_in} == 5'b0 && pi == 0 && cycle_cnt == 0,
        "R1 idle after reset", int'({busy, done, fail, scan_en, scan_in}), 0);
    for (int r = 0; r < NRUN; r++) run_seq(RUNS[r][2:1], RUNS[r][0], 1'b0);
    run_seq(2'd0, 1'b0, 1'b1);
    run_seq(2'd2, 1'b1, 1'b1);
    summary();
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog: run did not finish actual=%0d expected=%0d", 5000, 0);
    summary();
    $finish;
  end
endmodule